// File: doc/BRIEF.md
# Dual-Field Carry-Select Four-Operand Adder

This block sums four wide operands in a single clock stage. It can run as an integer adder for prime-field arithmetic or as a carry-free adder for binary-extension-field (GF(2^m)) arithmetic. A bank of 4-2 compressor cells reduces the four operands to a sum vector and a carry vector. When the block runs in binary-field mode, the compressor cells pass no carries. The two vectors then go to a split adder. The split adder cuts the word into fixed-width slices. Each slice forms its result twice, once for an incoming carry of 0 and once for an incoming carry of 1. A short chain of multiplexers, driven by the carry of the slice below, picks the correct copy of each slice. This keeps the longest carry path to one slice plus one selection step per slice, not the full operand width.

A typical use is inside a wide multiplier, where partial products are combined. The mode bit may change on every cycle. The result is registered, so it appears one clock after the inputs are presented.

Top module: `dfcs_adder`

## Requirements
- R1: With `mode_i` = 0 (prime field), `sum_o` equals the integer sum of the four operands, widened to WIDTH+2 bits. It is presented on the clock edge after the inputs are sampled.
- R2: With `mode_i` = 1 (binary field), `sum_o` equals the bitwise XOR of the four operands, with its two top bits equal to 0. It is presented on the clock edge after the inputs are sampled.
- R3: In prime mode, four operands that are all ones (2^WIDTH−1 each) give exactly 4·(2^WIDTH−1). No carry leaves the top of the result.
- R4: In binary mode, no carry leaves the compressor stage. Four all-ones operands therefore give 0.
- R5: Each slice forms a result for carry-in 0 and a result for carry-in 1. In prime mode the second result equals the first plus one. In binary mode the two results are the same.
- R6: The slice width SEG_W is a parameter, and WIDTH+2 need not be a multiple of it; the top slice may be narrower. A carry produced in the lowest slice reaches the top bit of the result correctly.
- R7: While `rst_n` is low, `sum_o` is 0.
- R8: The mode may change from one cycle to the next. Each result follows the mode that was sampled with its own operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; results register on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 1 | 0 = integer (prime-field) sum, 1 = carry-free (binary-field) sum |
| op_a_i | input | WIDTH | Operand A |
| op_b_i | input | WIDTH | Operand B |
| op_c_i | input | WIDTH | Operand C |
| op_d_i | input | WIDTH | Operand D |
| sum_o | output | WIDTH+2 | Registered result |

## Verification
The assertions assume that the operands and the mode are stable and known at each rising edge. They also assume the operands are no wider than WIDTH, so the two headroom bits of the compressor inputs are always zero. The bench drives every input only on the falling edge, with fully specified values. It zero-extends nothing itself, so all stimulus stays inside that assumed range. The stimulus covers random operands in both modes, all-ones operands, and a single carry that travels from bit 0 through every slice. It also switches the mode on every cycle, which tests that the mode is paired with the right result.

// File: rtl/dfcs_adder_pkg.sv
package dfcs_adder_pkg;

   typedef enum logic {
      FIELD_PRIME  = 1'b0,
      FIELD_BINARY = 1'b1
   } field_mode_e;

   function automatic int seg_count(input int total_w, input int seg_w);
      return (total_w + seg_w - 1) / seg_w;
   endfunction

   function automatic int seg_lo(input int idx, input int seg_w);
      return idx * seg_w;
   endfunction

   function automatic int seg_hi(input int idx, input int seg_w, input int total_w);
      return ((idx + 1) * seg_w > total_w) ? total_w : (idx + 1) * seg_w;
   endfunction

endpackage

// File: rtl/dfcs_compress42.sv
module dfcs_compress42 #(
   parameter int W = 8
) (
   input  logic         binary_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic [W-1:0] c_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] sum_o,
   output logic [W-1:0] carry_o,
   output logic         spill_o
);

   logic [W-1:0] part;
   logic [W-1:0] side_out;
   logic [W-1:0] side_in;

   if (W < 2) begin : g_bad_w
      $error("dfcs_compress42: W must be at least 2");
   end

   always_comb begin
      part     = a_i ^ b_i ^ c_i;
      side_out = binary_i ? '0 : ((a_i & b_i) | (a_i & c_i) | (b_i & c_i));
      side_in  = {side_out[W-2:0], 1'b0};
      sum_o    = part ^ d_i ^ side_in;
      carry_o  = binary_i ? '0 : ((part & d_i) | (part & side_in) | (d_i & side_in));
      spill_o  = side_out[W-1];
   end

   always_comb begin
      if (binary_i) begin
         AST_CMP_XOR: assert (sum_o == (a_i ^ b_i ^ c_i ^ d_i))
            else $error("compressor sum is not the four-way XOR"); // R4
      end else begin
         AST_CMP_CONSERVE: assert (({2'b00, a_i} + {2'b00, b_i} + {2'b00, c_i} + {2'b00, d_i}) ==
                                   ({2'b00, sum_o} + {1'b0, carry_o, 1'b0} + {1'b0, spill_o, {W{1'b0}}}))
            else $error("compressor does not preserve the operand total"); // R1
      end
   end

endmodule

// File: rtl/dfcs_segment.sv
module dfcs_segment #(
   parameter int W = 16
) (
   input  logic         binary_i,
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   output logic [W-1:0] sum0_o,
   output logic [W-1:0] sum1_o,
   output logic         cout0_o,
   output logic         cout1_o
);

   logic [W:0] with0;
   logic [W:0] with1;

   if (W < 1) begin : g_bad_w
      $error("dfcs_segment: W must be at least 1");
   end

   always_comb begin
      if (binary_i) begin
         with0 = {1'b0, x_i ^ y_i};
         with1 = {1'b0, x_i ^ y_i};
      end else begin
         with0 = {1'b0, x_i} + {1'b0, y_i};
         with1 = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, 1'b1};
      end
      {cout0_o, sum0_o} = with0;
      {cout1_o, sum1_o} = with1;
   end

   always_comb begin
      if (binary_i) begin
         AST_SEG_SAME: assert ({cout1_o, sum1_o} == {cout0_o, sum0_o} && !cout0_o)
            else $error("binary slice copies differ or carry"); // R5
      end else begin
         AST_SEG_PAIR: assert ({cout1_o, sum1_o} == ({cout0_o, sum0_o} + 1'b1))
            else $error("slice carry-in-1 copy is not one above carry-in-0 copy"); // R5
      end
   end

endmodule

// File: rtl/dfcs_select_adder.sv
module dfcs_select_adder #(
   parameter int W     = 32,
   parameter int SEG_W = 8
) (
   input  logic         binary_i,
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   output logic [W-1:0] sum_o,
   output logic         cout_o
);
   import dfcs_adder_pkg::*;

   localparam int NSEG = seg_count(W, SEG_W);

   logic [NSEG:0] chain;

   if (SEG_W < 1 || SEG_W > W) begin : g_bad_seg
      $error("dfcs_select_adder: SEG_W must lie in 1..W");
   end

   assign chain[0] = 1'b0;

   for (genvar g = 0; g < NSEG; g++) begin : g_seg
      localparam int LO = seg_lo(g, SEG_W);
      localparam int HI = seg_hi(g, SEG_W, W);
      localparam int SW = HI - LO;

      logic [SW-1:0] s0;
      logic [SW-1:0] s1;
      logic          c0;
      logic          c1;

      dfcs_segment #(.W(SW)) u_seg (
         .binary_i (binary_i),
         .x_i      (x_i[HI-1:LO]),
         .y_i      (y_i[HI-1:LO]),
         .sum0_o   (s0),
         .sum1_o   (s1),
         .cout0_o  (c0),
         .cout1_o  (c1)
      );

      if (g == 0) begin : g_first
         assign sum_o[HI-1:LO] = s0;
         assign chain[g+1]     = c0;
         logic unused_first;
         assign unused_first = ^{s1, c1};
      end else begin : g_upper
         assign sum_o[HI-1:LO] = chain[g] ? s1 : s0;
         assign chain[g+1]     = chain[g] ? c1 : c0;
      end
   end

   assign cout_o = chain[NSEG];

endmodule

// File: rtl/dfcs_adder.sv
module dfcs_adder #(
   parameter int WIDTH = 130,
   parameter int SEG_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mode_i,
   input  logic [WIDTH-1:0]   op_a_i,
   input  logic [WIDTH-1:0]   op_b_i,
   input  logic [WIDTH-1:0]   op_c_i,
   input  logic [WIDTH-1:0]   op_d_i,
   output logic [WIDTH+1:0]   sum_o
);
   import dfcs_adder_pkg::*;

   localparam int OUT_W = WIDTH + 2;

   if (WIDTH < 2) begin : g_bad_width
      $error("dfcs_adder: WIDTH must be at least 2");
   end
   if (SEG_W < 1 || SEG_W > OUT_W) begin : g_bad_seg
      $error("dfcs_adder: SEG_W must lie in 1..WIDTH+2");
   end

   field_mode_e      mode;
   logic             binary;
   logic [OUT_W-1:0] ext_a, ext_b, ext_c, ext_d;
   logic [OUT_W-1:0] red_sum, red_carry, shifted_carry;
   logic [OUT_W-1:0] comb_sum;
   logic             cmp_spill;
   logic             add_spill;

   assign mode   = field_mode_e'(mode_i);
   assign binary = (mode == FIELD_BINARY);
   assign ext_a  = {2'b00, op_a_i};
   assign ext_b  = {2'b00, op_b_i};
   assign ext_c  = {2'b00, op_c_i};
   assign ext_d  = {2'b00, op_d_i};

   dfcs_compress42 #(.W(OUT_W)) u_cmp (
      .binary_i (binary),
      .a_i      (ext_a),
      .b_i      (ext_b),
      .c_i      (ext_c),
      .d_i      (ext_d),
      .sum_o    (red_sum),
      .carry_o  (red_carry),
      .spill_o  (cmp_spill)
   );

   assign shifted_carry = {red_carry[OUT_W-2:0], 1'b0};

   dfcs_select_adder #(.W(OUT_W), .SEG_W(SEG_W)) u_add (
      .binary_i (binary),
      .x_i      (red_sum),
      .y_i      (shifted_carry),
      .sum_o    (comb_sum),
      .cout_o   (add_spill)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sum_o <= '0;
      end else begin
         sum_o <= comb_sum;
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmp_spill || red_carry[OUT_W-1] || add_spill)) else $error("carry left the result"); // R3

   AST_PRIME_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 1'b0) |=> (sum_o == ($past(ext_a) + $past(ext_b) + $past(ext_c) + $past(ext_d))))
      else $error("prime-mode result wrong"); // R1

   AST_BIN_XOR: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 1'b1) |=> (sum_o == ($past(ext_a) ^ $past(ext_b) ^ $past(ext_c) ^ $past(ext_d))))
      else $error("binary-mode result wrong"); // R2

   AST_BIN_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 1'b1) |=> (sum_o[OUT_W-1:WIDTH] == 2'b00))
      else $error("binary-mode headroom bits set"); // R2

   AST_RESET_ZERO: assert property (@(posedge clk)
      !rst_n |=> (sum_o == '0)) else $error("result not cleared by reset"); // R7

endmodule

// File: tb/dfcs_adder_test.sv
module dfcs_adder_test;

   localparam int CLK_PERIOD = 10;
   localparam int W  = 130;
   localparam int SW = 16;
   localparam int OW = W + 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode = 1'b0;
   logic [W-1:0]  a = '0, b = '0, c = '0, d = '0;
   logic [OW-1:0] sum;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [OW-1:0] exp_q[$];
   string         tag_q[$];

   dfcs_adder #(.WIDTH(W), .SEG_W(SW)) uut (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode_i (mode),
      .op_a_i (a),
      .op_b_i (b),
      .op_c_i (c),
      .op_d_i (d),
      .sum_o  (sum)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [W-1:0] rnd();
      logic [159:0] t;
      t = {$urandom, $urandom, $urandom, $urandom, $urandom};
      return t[W-1:0];
   endfunction

   task automatic check(input string tag, input logic [OW-1:0] act, input logic [OW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // One cycle: compare the oldest pending result, then apply new operands.
   task automatic step(input string tag, input logic m,
                       input logic [W-1:0] ia, input logic [W-1:0] ib,
                       input logic [W-1:0] ic, input logic [W-1:0] id);
      logic [OW-1:0] e;
      @(negedge clk);
      if (exp_q.size() > 0) check(tag_q.pop_front(), sum, exp_q.pop_front());
      mode = m; a = ia; b = ib; c = ic; d = id;
      if (m == 1'b0) e = OW'(ia) + OW'(ib) + OW'(ic) + OW'(id);
      else           e = OW'(ia ^ ib ^ ic ^ id);
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   task automatic drain();
      while (exp_q.size() > 0) begin
         @(negedge clk);
         check(tag_q.pop_front(), sum, exp_q.pop_front());
      end
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 100000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin : main
      logic [W-1:0] ones;
      logic [W-1:0] one;
      ones = '1;
      one  = {{(W-1){1'b0}}, 1'b1};

      // R7: reset clears result even with operands present
      a = ones; b = ones; c = ones; d = ones;
      repeat (3) begin
         @(negedge clk);
         check("R7 reset", sum, '0);
      end
      rst_n = 1'b1;

      // R1: random prime-field sums
      for (int i = 0; i < 40; i++) step("R1 prime random", 1'b0, rnd(), rnd(), rnd(), rnd());
      // R2: random binary-field sums
      for (int i = 0; i < 40; i++) step("R2 binary random", 1'b1, rnd(), rnd(), rnd(), rnd());
      // R3: maximum operands in prime mode
      step("R3 all-ones prime", 1'b0, ones, ones, ones, ones);
      // R4: maximum operands in binary mode give zero
      step("R4 all-ones binary", 1'b1, ones, ones, ones, ones);
      // R6: single carry travels through every slice
      step("R6 ripple from bit 0", 1'b0, ones, one, '0, '0);
      step("R6 ripple two ones", 1'b0, ones, ones, one, one);
      // R5: carry-in-1 copies selected in every slice, and identical copies in binary
      step("R5 select carry-in-1", 1'b0, ones, ones, ones, one);
      step("R5 binary copies", 1'b1, ones, one, '0, ones);
      // R8: mode toggles every cycle
      for (int i = 0; i < 30; i++) step("R8 mode toggle", i[0], rnd(), rnd(), ones, rnd());
      drain();

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule